// File: doc/BRIEF.md
# Link-Coupled Rotate and Shift Unit

This block carries out the rotate and shift instruction group of a 16-bit accumulator machine. The instruction word arrives with a valid strobe, together with the current accumulator and link bit. One clock edge later the block presents the new accumulator and link, and raises a one-cycle completion pulse or a one-cycle illegal-encoding pulse. Rotates treat the link and the accumulator as one 17-bit ring. Shifts act on the accumulator alone and leave the link unchanged.

There are four operations, and each takes a step count of 1, 2 or 3. Rotate-left and rotate-right move bits through the link. Shift-left keeps the sign bit fixed and loses bits that leave position 14. Shift-right is arithmetic. A group word whose count field is zero is illegal. A word from outside the group is ignored, because other units decode it.

Top module: `link_rot_shift`

## Requirements
- R1: A word belongs to the group when bits [15:6] equal octal 030 and bits [3:2] are zero. Bits [5:4] select the operation (0 rotate-left, 1 rotate-right, 2 shift-left, 3 shift-right) and bits [1:0] give the count. With the strobe high and a nonzero count, `done_o` is high in the next cycle only, and the new values appear on `ac_o`/`link_o` in that same cycle.
- R2: In rotate-left, each step moves accumulator bit 15 into the link and moves the old link into accumulator bit 0. The remaining bits move up one place.
- R3: In rotate-right, each step moves accumulator bit 0 into the link and moves the old link into accumulator bit 15. The remaining bits move down one place.
- R4: In shift-left, bit 15 is kept. Bits [14:0] move left by the count, with zeros entering at the bottom. The link output equals the link input.
- R5: In shift-right, the sign bit fills each vacated upper position. The link output equals the link input.
- R6: A group word with count 0 raises `illegal_o` for exactly the next cycle. It does not raise `done_o`, and `ac_o`/`link_o` keep their previous values.
- R7: A word outside the group (including one with bits [3:2] nonzero) raises neither pulse and leaves `ac_o`/`link_o` unchanged.
- R8: After reset, `ac_o` is 0, `link_o` is 0, `done_o` is 0 and `illegal_o` is 0.
- R9: While the strobe is low, `ac_o` and `link_o` hold and both pulses stay low.
- R10: Strobes on consecutive cycles each produce their own result in the cycle after their own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| instr_i | input | 16 | Instruction word |
| ac_i | input | 16 | Current accumulator |
| link_i | input | 1 | Current link bit |
| ac_o | output | 16 | Registered new accumulator |
| link_o | output | 1 | Registered new link bit |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle illegal-count pulse |

## Verification
The completion pulse and the illegal pulse can fall in adjacent cycles, and the risk is that one leaks into the other's cycle. The same risk applies to the result registers, which could update on an illegal word. The bench provokes this with unbroken strobe trains that mix legal words, count-zero words, words with reserved bits set and foreign words. A behavioural model runs beside the design and decides, cycle by cycle, which pulse must be high and whether the result registers must hold.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int WORD_W  = 16;
  localparam int CNT_W   = 2;
  localparam int OP_W    = 2;
  localparam int GRP_W   = WORD_W - 6;
  localparam logic [GRP_W-1:0] GRP_CODE = 10'o030;

  typedef enum logic [OP_W-1:0] {
    OP_ROT_L = 2'd0,
    OP_ROT_R = 2'd1,
    OP_SHL_S = 2'd2,
    OP_SHR_A = 2'd3
  } lrs_op_e;

  typedef struct packed {
    logic               in_group;
    logic               legal;
    logic               bad_count;
    lrs_op_e            op;
    logic [CNT_W-1:0]   count;
  } lrs_dec_t;
endpackage

// File: rtl/lrs_decode.sv
module lrs_decode
  import lrs_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] word_i,
  output lrs_dec_t     dec_o
);
  localparam int GRP_LO = 6;

  logic grp_hit;
  logic rsv_zero;

  always_comb begin
    grp_hit  = (word_i[W-1:GRP_LO] == GRP_CODE);
    rsv_zero = (word_i[3:2] == 2'b00);
    dec_o.in_group  = grp_hit && rsv_zero;
    dec_o.op        = lrs_op_e'(word_i[5:4]);
    dec_o.count     = word_i[CNT_W-1:0];
    dec_o.bad_count = dec_o.in_group && (word_i[CNT_W-1:0] == '0);
    dec_o.legal     = dec_o.in_group && (word_i[CNT_W-1:0] != '0);
  end
endmodule

// File: rtl/lrs_ring_rotator.sv
module lrs_ring_rotator #(
  parameter int W     = 16,
  parameter int CNT_W = 2
) (
  input  logic [W:0]       ring_i,
  input  logic             right_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [W:0]       ring_o
);
  localparam int STEPS = (1 << CNT_W) - 1;

  logic [W:0] lft [0:STEPS];
  logic [W:0] rgt [0:STEPS];

  assign lft[0] = ring_i;
  assign rgt[0] = ring_i;

  genvar k;
  generate
    for (k = 1; k <= STEPS; k++) begin : g_step
      assign lft[k] = {lft[k-1][W-1:0], lft[k-1][W]};
      assign rgt[k] = {rgt[k-1][0], rgt[k-1][W:1]};
    end
  endgenerate

  always_comb begin
    ring_o = right_i ? rgt[count_i] : lft[count_i];
  end
endmodule

// File: rtl/lrs_sign_shifter.sv
module lrs_sign_shifter #(
  parameter int W     = 16,
  parameter int CNT_W = 2
) (
  input  logic [W-1:0]     val_i,
  input  logic             right_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [W-1:0]     val_o
);
  localparam int STEPS = (1 << CNT_W) - 1;

  logic [W-1:0] sl [0:STEPS];
  logic [W-1:0] sr [0:STEPS];

  assign sl[0] = val_i;
  assign sr[0] = val_i;

  genvar k;
  generate
    for (k = 1; k <= STEPS; k++) begin : g_step
      assign sl[k] = {sl[k-1][W-1], sl[k-1][W-3:0], 1'b0};
      assign sr[k] = {sr[k-1][W-1], sr[k-1][W-1:1]};
    end
  endgenerate

  always_comb begin
    val_o = right_i ? sr[count_i] : sl[count_i];
  end
endmodule

// File: rtl/link_rot_shift.sv
module link_rot_shift
  import lrs_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CW = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] instr_i,
  input  logic [W-1:0] ac_i,
  input  logic         link_i,
  output logic [W-1:0] ac_o,
  output logic         link_o,
  output logic         done_o,
  output logic         illegal_o
);
  lrs_dec_t   dec;
  logic [W:0] ring_new;
  logic [W-1:0] sh_new;
  logic [W-1:0] ac_nxt;
  logic       link_nxt;
  logic       is_shift;

  lrs_decode #(.W(W)) u_dec (
    .word_i (instr_i),
    .dec_o  (dec)
  );

  lrs_ring_rotator #(.W(W), .CNT_W(CW)) u_rot (
    .ring_i  ({link_i, ac_i}),
    .right_i (dec.op == OP_ROT_R),
    .count_i (dec.count),
    .ring_o  (ring_new)
  );

  lrs_sign_shifter #(.W(W), .CNT_W(CW)) u_shf (
    .val_i   (ac_i),
    .right_i (dec.op == OP_SHR_A),
    .count_i (dec.count),
    .val_o   (sh_new)
  );

  always_comb begin
    is_shift = (dec.op == OP_SHL_S) || (dec.op == OP_SHR_A);
    if (is_shift) begin
      ac_nxt   = sh_new;
      link_nxt = link_i;
    end else begin
      ac_nxt   = ring_new[W-1:0];
      link_nxt = ring_new[W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_o      <= '0;
      link_o    <= 1'b0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= in_valid && dec.legal;
      illegal_o <= in_valid && dec.bad_count;
      if (in_valid && dec.legal) begin
        ac_o   <= ac_nxt;
        link_o <= link_nxt;
      end
    end
  end

  // R6: the two pulses never share a cycle
  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(done_o && illegal_o));

  // R1: completion only follows a strobe
  p_done_after_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(in_valid));

  // R9: no strobe, no change
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(ac_o) && $stable(link_o) && !done_o && !illegal_o));

  // R6: illegal word leaves result untouched
  p_illegal_hold_r6: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> ($stable(ac_o) && $stable(link_o)));

  // R4: shift-left keeps sign and link
  p_shl_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.legal && dec.op == OP_SHL_S) |=>
      (ac_o[W-1] == $past(ac_i[W-1]) && link_o == $past(link_i)));

  // R5: shift-right keeps sign and link
  p_shr_sign_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.legal && dec.op == OP_SHR_A) |=>
      (ac_o[W-1] == $past(ac_i[W-1]) && link_o == $past(link_i)));

  // R2: one-step rotate-left moves old bit 15 into the link
  p_rotl_link_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.op == OP_ROT_L && dec.in_group && dec.count == 1) |=>
      (link_o == $past(ac_i[W-1]) && ac_o[0] == $past(link_i)));
endmodule

// File: tb/link_rot_shift_tb.sv
module link_rot_shift_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [W-1:0] instr_i;
  logic [W-1:0] ac_i;
  logic         link_i;
  logic [W-1:0] ac_o;
  logic         link_o;
  logic         done_o;
  logic         illegal_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [W-1:0] m_ac;
  logic         m_link;
  logic         m_done;
  logic         m_ill;
  string        m_tag;
  logic [31:0]  lfsr = 32'hACE1_2357;

  always #10 clk = ~clk;

  link_rot_shift u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr_i(instr_i),
    .ac_i(ac_i), .link_i(link_i), .ac_o(ac_o), .link_o(link_o),
    .done_o(done_o), .illegal_o(illegal_o)
  );

  task automatic check_all();
    n_cmp++;
    if (ac_o !== m_ac || link_o !== m_link || done_o !== m_done || illegal_o !== m_ill) begin
      n_bad++;
      $display("FAIL %s: got ac=%o l=%0b d=%0b i=%0b expected ac=%o l=%0b d=%0b i=%0b",
               m_tag, ac_o, link_o, done_o, illegal_o, m_ac, m_link, m_done, m_ill);
    end
  endtask

  // behavioural reference: applies one strobe (or idle) to the model state
  task automatic model_apply(input logic v, input logic [W-1:0] w,
                             input logic [W-1:0] a, input logic l);
    int cnt;
    int op;
    logic [W-1:0] x;
    logic         y;
    logic         t;
    m_done = 1'b0;
    m_ill  = 1'b0;
    if (!v) begin
      m_tag = "R9 idle";
      return;
    end
    if (w[15:6] != 10'o030 || w[3:2] != 2'b00) begin
      m_tag = "R7 foreign";
      return;
    end
    cnt = int'(w[1:0]);
    op  = int'(w[5:4]);
    if (cnt == 0) begin
      m_ill = 1'b1;
      m_tag = "R6 count0";
      return;
    end
    x = a;
    y = l;
    for (int s = 0; s < cnt; s++) begin
      case (op)
        0: begin t = x[15]; x = {x[14:0], y}; y = t; end
        1: begin t = x[0];  x = {y, x[15:1]}; y = t; end
        2: x = {x[15], x[13:0], 1'b0};
        default: x = {x[15], x[15:1]};
      endcase
    end
    case (op)
      0: m_tag = "R2 rotl";
      1: m_tag = "R3 rotr";
      2: m_tag = "R4 shl";
      default: m_tag = "R5 shr";
    endcase
    m_ac   = x;
    m_link = y;
    m_done = 1'b1;
  endtask

  // drive at negedge after checking the previous cycle's result
  task automatic step(input logic v, input logic [W-1:0] w,
                      input logic [W-1:0] a, input logic l);
    @(negedge clk);
    check_all();
    in_valid = v;
    instr_i  = w;
    ac_i     = a;
    link_i   = l;
    model_apply(v, w, a, l);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] w;
    rst = 1'b1; in_valid = 1'b0; instr_i = '0; ac_i = '0; link_i = 1'b0;
    m_ac = '0; m_link = 1'b0; m_done = 1'b0; m_ill = 1'b0; m_tag = "R8 reset";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all();                 // R8 reset state
    rst = 1'b0;
    m_tag = "R8 reset";

    // R2 rotate left, counts 1..3
    step(1, 16'o003001, 16'o100001, 1'b0);   // -> ac 000002, l 1
    step(1, 16'o003002, 16'o140000, 1'b1);
    step(1, 16'o003003, 16'o123456, 1'b1);
    // R3 rotate right
    step(1, 16'o003021, 16'o000001, 1'b1);   // -> ac 100000, l 1
    step(1, 16'o003023, 16'o123456, 1'b0);
    // R4 sign-kept shift left, bits lost at 14
    step(1, 16'o003041, 16'o140001, 1'b1);   // -> ac 100002, l 1
    step(1, 16'o003043, 16'o077777, 1'b0);
    // R5 arithmetic shift right
    step(1, 16'o003061, 16'o100000, 1'b0);   // -> ac 140000
    step(1, 16'o003063, 16'o040000, 1'b1);
    // R6 count 0, then R9 idle holds
    step(1, 16'o003000, 16'o177777, 1'b0);
    step(1, 16'o003060, 16'o000000, 1'b1);
    step(0, 16'o003001, 16'o177777, 1'b1);
    // R7 reserved bits / foreign words
    step(1, 16'o003005, 16'o111111, 1'b1);
    step(1, 16'o013001, 16'o111111, 1'b1);
    step(1, 16'o100001, 16'o111111, 1'b1);
    // R10 back-to-back mixed train
    for (int i = 0; i < 3000; i++) begin
      lfsr = nxt(lfsr);
      case (lfsr[3:2])
        2'd0, 2'd1: w = {10'o030, 2'(lfsr[7:6]), 2'b00, 2'(lfsr[9:8])};
        2'd2: w = {10'o030, 2'(lfsr[7:6]), 2'(lfsr[11:10]), 2'(lfsr[9:8])};
        default: w = lfsr[31:16];
      endcase
      step(lfsr[12] | lfsr[13], w, lfsr[27:12], lfsr[5]);
    end
    step(0, '0, '0, 1'b0);
    @(negedge clk);
    check_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule